// File: doc/BRIEF.md
# MMU Access Rights and Fault Unit

This block sits behind the address translation walker of a memory management unit. For each access that has already been translated it receives the kind of access (instruction fetch, data read or data write), whether the processor is in a privileged mode, the 4-bit protection domain and the 2-bit access-permission field of the matching descriptor, whether the descriptor was a section or a page, the 32-bit domain access word, two system control bits (called system-protect and rom-protect here), and a flag saying the walk itself failed. From these it decides in the same cycle whether the access proceeds, whether the translation may be cached, or which abort it raises.

On a data-side fault it loads an 8-bit fault status register and a fault address register at the clock edge where the abort strobe is high. An instruction fetch raises a prefetch abort instead. Fetch walk failures and fetch permission failures leave both registers alone. Fetch domain faults do load them. Software-visible reads of the two registers go through a small select-driven read port. When the MMU is switched off, every checked access is allowed and no buffer fill is requested.

Top module: `mmu_rights_unit`

## Requirements
- R1: With `check_en` low all of `allow`, `dabort`, `pabort` and `fill_en` are 0. With `check_en` high and `mmu_on` low, `allow` is 1 and the other three are 0.
- R2: The 2-bit domain code is taken from `dacr` bits [2*dom+1 : 2*dom]. Code 0 raises a domain fault with status 0x9 for a section or 0xB for a page.
- R3: Code 3 allows the access with no permission check and asserts `fill_en`. Code 2 allows it with no check and keeps `fill_en` low.
- R4: Code 1 (client), ap = 0, read or fetch: with `sys_s`=1 and `rom_r`=0 only privileged accesses pass. With `sys_s`=0 and `rom_r`=1 all accesses pass. With both 0 or both 1 the access is denied.
- R5: Code 1, ap = 0, write: always denied, whatever `sys_s`, `rom_r` and `priv` are.
- R6: Code 1, ap != 0: a privileged access always passes. For a user access, ap = 1 denies, ap = 2 passes reads and fetches only, and ap = 3 passes everything.
- R7: A client access that passes asserts `allow` and `fill_en` together.
- R8: `xlat_fault` takes priority over every domain and permission check. Its status is 0x5 for a section or 0x7 for a page.
- R9: A client permission failure has status 0xD for a section or 0xF for a page.
- R10: A fault on a read or write (acc_kind 01 = read, 1x = write) pulses `dabort`. At that clock edge the fault status register loads {dom, status} and the fault address register loads `vaddr`. `rd_sel`=0 returns the status register zero-extended and `rd_sel`=1 returns the address register. Both registers are 0 after reset.
- R11: A fault on a fetch (acc_kind 00) pulses `pabort` only and never `dabort`. On a fetch, walk failures and permission failures leave both fault registers unchanged, while a fetch domain fault loads them as in R10.
- R12: In any cycle at most one of `allow`, `dabort` and `pabort` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| check_en | input | 1 | An access is presented this cycle |
| mmu_on | input | 1 | MMU enable |
| acc_kind | input | 2 | 00 fetch, 01 read, 1x write |
| priv | input | 1 | Privileged access |
| dom | input | 4 | Protection domain number |
| ap | input | 2 | Access-permission field |
| is_section | input | 1 | 1 = section descriptor, 0 = page |
| dacr | input | 32 | Domain access word, 2 bits per domain |
| sys_s | input | 1 | System-protect control bit |
| rom_r | input | 1 | Rom-protect control bit |
| xlat_fault | input | 1 | The translation walk failed |
| vaddr | input | 32 | Virtual address of the access |
| rd_sel | input | 1 | 0 selects the fault status, 1 the fault address |
| allow | output | 1 | The access may proceed |
| dabort | output | 1 | Data abort strobe |
| pabort | output | 1 | Prefetch abort strobe |
| fill_en | output | 1 | The translation may be cached |
| rd_data | output | 32 | Selected fault register |

## Verification
The bench drives the ap = 0 cases under all four settings of the two control bits. A design that ignored the write override would let writes through with rom-protect set, and one that mixed up the bits would give user reads access under system-protect. It also hits domain code 2, where a wrong design would either fault or request a buffer fill, and a walk failure on a domain with code 0, where a design with the wrong priority would report 0x9/0xB instead of 0x5/0x7. Fetch faults of all three kinds are checked against the register contents. A design that updated the registers on every prefetch abort, or skipped the update on a fetch domain fault, leaves a wrong status or address behind.

// File: rtl/mmu_rights_pkg.sv
package mmu_rights_pkg;

   typedef enum logic [1:0] {
      DOM_DENY    = 2'd0,
      DOM_CLIENT  = 2'd1,
      DOM_RSVD    = 2'd2,
      DOM_MANAGER = 2'd3
   } dom_code_e;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_XLAT   = 2'd1,
      FK_DOMAIN = 2'd2,
      FK_PERM   = 2'd3
   } fault_kind_e;

   localparam int unsigned ST_W = 4;

   // status nibble: section codes are odd, page = section + 2
   function automatic logic [ST_W-1:0] fault_status(fault_kind_e fk, logic section);
      logic [ST_W-1:0] base;
      case (fk)
         FK_XLAT:   base = 4'h5;
         FK_DOMAIN: base = 4'h9;
         FK_PERM:   base = 4'hD;
         default:   base = 4'h0;
      endcase
      return section ? base : (base + 4'h2);
   endfunction

endpackage

// File: rtl/mmu_dom_gate.sv
module mmu_dom_gate
   import mmu_rights_pkg::*;
#(
   parameter int unsigned DOM_W = 4,
   localparam int unsigned NDOM = 1 << DOM_W
)(
   input  logic [2*NDOM-1:0] dacr,
   input  logic [DOM_W-1:0]  dom,
   output dom_code_e         code
);

   logic [1:0] slice [NDOM];

   for (genvar g = 0; g < NDOM; g++) begin : g_slice
      assign slice[g] = dacr[2*g +: 2];
   end

   assign code = dom_code_e'(slice[dom]);

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check (
   input  logic       is_write,
   input  logic       priv,
   input  logic [1:0] ap,
   input  logic       sys_s,
   input  logic       rom_r,
   output logic       ok
);

   always_comb begin
      ok = 1'b0;
      if (ap == 2'd0) begin
         if (!is_write) begin
            case ({sys_s, rom_r})
               2'b10:   ok = priv;
               2'b01:   ok = 1'b1;
               default: ok = 1'b0;
            endcase
         end
      end else if (priv) begin
         ok = 1'b1;
      end else begin
         case (ap)
            2'd2:    ok = !is_write;
            2'd3:    ok = 1'b1;
            default: ok = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned FSR_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FSR_W-1:0]  fsr_d,
   input  logic [ADDR_W-1:0] far_d,
   input  logic              rd_sel,
   output logic [FSR_W-1:0]  fsr_q,
   output logic [ADDR_W-1:0] far_q,
   output logic [ADDR_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else if (load) begin
         fsr_q <= fsr_d;
         far_q <= far_d;
      end
   end

   logic [ADDR_W-1:0] fsr_ext;

   if (ADDR_W > FSR_W) begin : g_pad
      assign fsr_ext = {{(ADDR_W-FSR_W){1'b0}}, fsr_q};
   end else begin : g_nopad
      assign fsr_ext = fsr_q;
   end

   assign rd_data = rd_sel ? far_q : fsr_ext;

endmodule

// File: rtl/mmu_rights_unit.sv
module mmu_rights_unit
   import mmu_rights_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DOM_W         = 4,
   parameter bit          FETCH_DOM_UPD = 1'b1,
   localparam int unsigned NDOM  = 1 << DOM_W,
   localparam int unsigned FSR_W = DOM_W + ST_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              check_en,
   input  logic              mmu_on,
   input  logic [1:0]        acc_kind,
   input  logic              priv,
   input  logic [DOM_W-1:0]  dom,
   input  logic [1:0]        ap,
   input  logic              is_section,
   input  logic [2*NDOM-1:0] dacr,
   input  logic              sys_s,
   input  logic              rom_r,
   input  logic              xlat_fault,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              rd_sel,
   output logic              allow,
   output logic              dabort,
   output logic              pabort,
   output logic              fill_en,
   output logic [ADDR_W-1:0] rd_data
);

   if (DOM_W < 1 || DOM_W > 4) begin : g_bad_dom
      $error("mmu_rights_unit: DOM_W must be 1..4");
   end
   if (FSR_W > ADDR_W) begin : g_bad_addr
      $error("mmu_rights_unit: ADDR_W too narrow for fault status");
   end

   logic        is_fetch, is_write, perm_ok, load;
   dom_code_e   code;
   fault_kind_e fk;
   logic [FSR_W-1:0]  fsr_q;
   logic [ADDR_W-1:0] far_q;

   assign is_fetch = (acc_kind == 2'b00);
   assign is_write = acc_kind[1];

   mmu_dom_gate #(.DOM_W(DOM_W)) gate_i (
      .dacr (dacr),
      .dom  (dom),
      .code (code)
   );

   mmu_perm_check perm_i (
      .is_write (is_write),
      .priv     (priv),
      .ap       (ap),
      .sys_s    (sys_s),
      .rom_r    (rom_r),
      .ok       (perm_ok)
   );

   always_comb begin
      allow   = 1'b0;
      fill_en = 1'b0;
      fk      = FK_NONE;
      if (check_en) begin
         if (!mmu_on) begin
            allow = 1'b1;
         end else if (xlat_fault) begin
            fk = FK_XLAT;
         end else begin
            case (code)
               DOM_DENY: fk = FK_DOMAIN;
               DOM_CLIENT: begin
                  if (perm_ok) begin
                     allow   = 1'b1;
                     fill_en = 1'b1;
                  end else begin
                     fk = FK_PERM;
                  end
               end
               DOM_RSVD: allow = 1'b1;
               default: begin
                  allow   = 1'b1;
                  fill_en = 1'b1;
               end
            endcase
         end
      end
   end

   assign dabort = (fk != FK_NONE) && !is_fetch;
   assign pabort = (fk != FK_NONE) && is_fetch;

   if (FETCH_DOM_UPD) begin : g_fetch_upd
      assign load = dabort || (pabort && fk == FK_DOMAIN);
   end else begin : g_fetch_keep
      assign load = dabort;
   end

   mmu_fault_regs #(.ADDR_W(ADDR_W), .FSR_W(FSR_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .fsr_d   ({dom, fault_status(fk, is_section)}),
      .far_d   (vaddr),
      .rd_sel  (rd_sel),
      .fsr_q   (fsr_q),
      .far_q   (far_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/mmu_rights_chk.sv
module mmu_rights_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DOM_W  = 4,
   localparam int unsigned FSR_W = DOM_W + 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              check_en,
   input logic              mmu_on,
   input logic [1:0]        acc_kind,
   input logic              xlat_fault,
   input logic [ADDR_W-1:0] vaddr,
   input logic              allow,
   input logic              dabort,
   input logic              pabort,
   input logic              fill_en,
   input logic [FSR_W-1:0]  fsr_q,
   input logic [ADDR_W-1:0] far_q
);

   // R12
   excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({allow, dabort, pabort}) <= 1);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !check_en |-> !(allow || dabort || pabort || fill_en));

   // R1
   off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && !mmu_on) |-> (allow && !dabort && !pabort && !fill_en));

   // R7
   fill_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> allow);

   // R10
   far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dabort |=> (far_q == $past(vaddr)));

   // R11
   fetch_no_dabort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'b00) |-> !dabort);

   // R11
   fetch_xlat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pabort && xlat_fault) |=> (far_q == $past(far_q) && fsr_q == $past(fsr_q)));

endmodule

bind mmu_rights_unit mmu_rights_chk #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) chk_i (.*);

// File: tb/mmu_rights_unit_tb_top.sv
`timescale 1ns/1ps
module mmu_rights_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        check_en = 1'b0, mmu_on = 1'b0, priv = 1'b0;
   logic [1:0]  acc_kind = 2'b01, ap = 2'd0;
   logic [3:0]  dom = 4'd0;
   logic        is_section = 1'b0, sys_s = 1'b0, rom_r = 1'b0, xlat_fault = 1'b0;
   logic [31:0] dacr = 32'd0, vaddr = 32'd0;
   logic        rd_sel = 1'b0;
   logic        allow, dabort, pabort, fill_en;
   logic [31:0] rd_data;

   int n_chk = 0, n_fail = 0;

   // expectations
   logic       e_allow, e_dab, e_pab, e_fill, e_load;
   logic [3:0] e_st;
   logic [7:0] e_fsr = 8'd0;
   logic [31:0] e_far = 32'd0;
   string      e_tag;

   always #10 clk = ~clk;

   mmu_rights_unit dut_i (
      .clk(clk), .rst_n(rst_n), .check_en(check_en), .mmu_on(mmu_on),
      .acc_kind(acc_kind), .priv(priv), .dom(dom), .ap(ap),
      .is_section(is_section), .dacr(dacr), .sys_s(sys_s), .rom_r(rom_r),
      .xlat_fault(xlat_fault), .vaddr(vaddr), .rd_sel(rd_sel),
      .allow(allow), .dabort(dabort), .pabort(pabort), .fill_en(fill_en),
      .rd_data(rd_data)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bench model derived from R1..R11
   task automatic predict();
      logic [1:0] c;
      logic fetch, wr, ok;
      int kind; // 0 none,1 xlat,2 dom,3 perm
      fetch = (acc_kind == 2'b00);
      wr = acc_kind[1];
      c = dacr[2*dom +: 2];
      e_allow = 0; e_fill = 0; kind = 0; e_st = 0; e_tag = "R3";
      if (!mmu_on) begin
         e_allow = 1; e_tag = "R1";
      end else if (xlat_fault) begin
         kind = 1; e_tag = "R8";
      end else if (c == 2'd0) begin
         kind = 2; e_tag = "R2";
      end else if (c == 2'd1) begin
         if (ap == 2'd0 && wr) begin
            ok = 0; e_tag = "R5";
         end else if (ap == 2'd0) begin
            e_tag = "R4";
            ok = (sys_s && !rom_r) ? priv : (!sys_s && rom_r);
         end else begin
            e_tag = "R6";
            ok = priv || ap == 2'd3 || (ap == 2'd2 && !wr);
         end
         if (ok) begin e_allow = 1; e_fill = 1; end
         else kind = 3;
      end else begin
         e_allow = 1; e_fill = (c == 2'd3);
      end
      case (kind)
         1: e_st = is_section ? 4'h5 : 4'h7;
         2: e_st = is_section ? 4'h9 : 4'hB;
         3: e_st = is_section ? 4'hD : 4'hF;
         default: e_st = 4'h0;
      endcase
      e_dab = (kind != 0) && !fetch;
      e_pab = (kind != 0) && fetch;
      e_load = e_dab || (e_pab && kind == 2);
   endtask

   task automatic access(logic on, logic [1:0] k, logic pv, logic [3:0] d,
                         logic [1:0] a, logic sec, logic [31:0] dc,
                         logic s, logic r, logic xf, logic [31:0] va);
      @(negedge clk);
      mmu_on = on; acc_kind = k; priv = pv; dom = d; ap = a; is_section = sec;
      dacr = dc; sys_s = s; rom_r = r; xlat_fault = xf; vaddr = va; check_en = 1'b1;
      #5;
      predict();
      chk({e_tag, " allow"}, {31'd0, allow}, {31'd0, e_allow});
      chk({e_tag, " dabort R10"}, {31'd0, dabort}, {31'd0, e_dab});
      chk({e_tag, " pabort R11"}, {31'd0, pabort}, {31'd0, e_pab});
      chk({e_tag, " fill_en R7"}, {31'd0, fill_en}, {31'd0, e_fill});
      chk("R12 exclusive", {31'd0, ($countones({allow, dabort, pabort}) <= 1)}, 32'd1);
      if (e_load) begin
         e_fsr = {d, e_st};
         e_far = va;
      end
      @(negedge clk);
      check_en = 1'b0;
      #1;
      chk("R1 idle", {28'd0, allow, dabort, pabort, fill_en}, 32'd0);
      rd_sel = 1'b0; #1;
      chk(e_load ? "R10 fsr" : "R11 fsr kept", rd_data, {24'd0, e_fsr});
      rd_sel = 1'b1; #1;
      chk(e_load ? "R10 far" : "R11 far kept", rd_data, e_far);
   endtask

   // dacr with domain d set to code c, others random
   function automatic logic [31:0] dac_with(logic [3:0] d, logic [1:0] c, logic [31:0] bg);
      logic [31:0] v = bg;
      v[2*d +: 2] = c;
      return v;
   endfunction

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // reset state R10
      rd_sel = 1'b0; #1;
      chk("R10 reset fsr", rd_data, 32'd0);
      rd_sel = 1'b1; #1;
      chk("R10 reset far", rd_data, 32'd0);
      chk("R1 reset idle", {28'd0, allow, dabort, pabort, fill_en}, 32'd0);
      rst_n = 1'b1;

      // R1 disabled
      access(0, 2'b10, 0, 4'd3, 2'd1, 0, 32'h0, 0, 0, 1, 32'h1111_0000);
      // R2 domain fault section/page, high domain bit position
      access(1, 2'b01, 1, 4'd15, 2'd3, 1, dac_with(15, 0, 32'h5555_5555), 0, 0, 0, 32'hA000_0004);
      access(1, 2'b10, 1, 4'd7, 2'd3, 0, dac_with(7, 0, 32'hFFFF_FFFF), 0, 0, 0, 32'hA000_0008);
      // R3 manager ignores ap, reserved code no fill
      access(1, 2'b10, 0, 4'd2, 2'd1, 0, dac_with(2, 3, 32'h0), 0, 0, 0, 32'h1);
      access(1, 2'b10, 0, 4'd9, 2'd1, 1, dac_with(9, 2, 32'h0), 0, 0, 0, 32'h2);
      // R4 all four control settings, user and privileged reads
      for (int sr = 0; sr < 4; sr++) begin
         access(1, 2'b01, 0, 4'd1, 2'd0, 1, dac_with(1, 1, 32'h0), sr[1], sr[0], 0, 32'hB000_0000 + sr);
         access(1, 2'b01, 1, 4'd1, 2'd0, 0, dac_with(1, 1, 32'h0), sr[1], sr[0], 0, 32'hB100_0000 + sr);
         // R5 writes denied under every setting, even privileged
         access(1, 2'b10, 1, 4'd1, 2'd0, 1, dac_with(1, 1, 32'h0), sr[1], sr[0], 0, 32'hC000_0000 + sr);
      end
      // R6 user ap 1/2/3 reads and writes
      for (int a = 1; a < 4; a++) begin
         access(1, 2'b01, 0, 4'd4, a[1:0], 0, dac_with(4, 1, 32'h0), 0, 0, 0, 32'hD000_0000 + a);
         access(1, 2'b11, 0, 4'd4, a[1:0], 1, dac_with(4, 1, 32'h0), 0, 0, 0, 32'hD100_0000 + a);
      end
      // R8 walk failure beats domain fault; R9 permission code
      access(1, 2'b01, 0, 4'd5, 2'd1, 1, dac_with(5, 0, 32'h0), 0, 0, 1, 32'hE000_0010);
      access(1, 2'b01, 0, 4'd5, 2'd1, 0, dac_with(5, 1, 32'h0), 0, 0, 0, 32'hE000_0020);
      // R11 fetch faults: xlat and perm keep regs, domain loads them
      access(1, 2'b00, 0, 4'd6, 2'd1, 1, dac_with(6, 1, 32'h0), 0, 0, 1, 32'hF000_0001);
      access(1, 2'b00, 0, 4'd6, 2'd1, 1, dac_with(6, 1, 32'h0), 0, 0, 0, 32'hF000_0002);
      access(1, 2'b00, 0, 4'd6, 2'd1, 0, dac_with(6, 0, 32'h0), 0, 0, 0, 32'hF000_0003);

      // constrained random
      for (int i = 0; i < 1500; i++) begin
         access(($urandom % 10) != 0, 2'($urandom), 1'($urandom), 4'($urandom),
                2'($urandom), 1'($urandom), $urandom, 1'($urandom), 1'($urandom),
                ($urandom % 8) == 0, $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule